// File: doc/BRIEF.md
# Serial SAR Converter Interface Engine

This block is the device-side digital control of a two-channel, 12-bit successive-approximation converter that is reached over a three-wire serial port. A host pulls the active-low select low and clocks in a command: a start bit, a single-ended/differential choice, a channel or polarity choice, and an output-order choice. The block then opens a sample window, latches the selected input level, and shifts out a low null bit and one resolved result bit per serial clock. Each bit is decided against an ideal DAC/comparator model. An optional LSB-first replay and then zeros follow. The two channel levels arrive as 12-bit digital stand-ins for analog voltages.

The serial clock, select and data-in pins are treated as asynchronous. They pass through a synchronizer into a single system-clock domain, and edges are detected there, so the host's serial clock must be several system clocks slower than `clk`. The command and the result share one select frame. Raising select at any point ends the frame and parks the block in standby.

Top module: `adc_sif_engine`

## Requirements
- R1: After reset the block is in standby (`standby`=1, `sdo_en`=0). A frame begins only on a falling edge of `cs_n` that follows a high level of `cs_n` seen after reset. If `cs_n` is low while reset is released, nothing is accepted until `cs_n` has gone high and low again.
- R2: While a frame hunts for its start, rising serial edges that sample `sdi`=0 are ignored. The first rising edge that samples `sdi`=1 is the start bit.
- R3: The next three rising edges capture, in order, the mode bit (1 = single-ended, 0 = differential), the select bit, and the order bit (1 = MSB-first only, 0 = MSB-first then LSB-first replay).
- R4: Single-ended mode with select 0 converts channel 0, and with select 1 converts channel 1.
- R5: `sample_win` rises on the second rising edge after the start bit. It falls on the falling edge of the third clock after the start bit, which is the order-bit clock.
- R6: `sdo_en` stays low until that same falling edge, where it goes high with `sdo`=0 as the null bit.
- R7: The next 12 falling edges drive the result bits from bit 11 down to bit 0, and `sdo` changes only after a serial falling edge or on a select rise.
- R8: With the order bit at 1, every falling edge after bit 0 drives 0.
- R9: With the order bit at 0, the falling edges after bit 0 drive bits 1 through 11 in rising order, and 0 after that.
- R10: Differential mode with select 0 takes channel 0 as the positive input and channel 1 as the negative input. Select 1 swaps the two. The result is the positive level minus the negative level, and 0 when the positive level is at or below the negative level.
- R11: A high level on `cs_n` at any time ends the frame: `sdo_en` and `sample_win` go low, `sdo` goes to 0 and `standby` goes high.
- R12: The selected level is held at the close of the sample window, and later changes on the channel inputs do not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select (asynchronous) |
| sclk | input | 1 | Serial clock from the host (asynchronous) |
| sdi | input | 1 | Serial command data, sampled on rising serial edges |
| ch0_code | input | RES_W | Digital stand-in for the channel 0 level |
| ch1_code | input | RES_W | Digital stand-in for the channel 1 level |
| sdo | output | 1 | Serial result data, valid while `sdo_en` is high |
| sdo_en | output | 1 | Drive enable for `sdo` (low = high impedance) |
| sample_win | output | 1 | High while the input is being sampled |
| standby | output | 1 | High while no frame is active |

## Verification
The bench builds the block with its defaults: a 12-bit result and a two-stage synchronizer. It runs the serial clock at six system clocks per half period, so each serial edge settles through the three-cycle synchronize-and-detect path before the next edge arrives. At this width every code can appear, including all-zeros, all-ones and the clamp at equal inputs. The model therefore compares outputs exactly, one clock after another, while frames run in both serial clock polarities. Channel inputs are inverted right after the window closes. Frames are also cut off mid-conversion, and one reset is applied with select held low.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;

  // Frame sequencer states
  typedef enum logic [2:0] {
    S_OFF,     // standby, waiting for a qualified select fall
    S_HUNT,    // select low, skipping leading zeros
    S_CFG,     // capturing the command bits
    S_CONV,    // resolving and shifting MSB-first result
    S_REPLAY,  // shifting LSB-first replay
    S_FILL     // driving zeros until select rises
  } eng_state_t;

  // Number of command bits that follow the start bit
  localparam int CFG_BITS = 3;

endpackage

// File: rtl/adc_sif_sync.sv
module adc_sif_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg_q[0] <= '0;
    else     stg_q[0] <= d_in;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg_q[g] <= '0;
      else     stg_q[g] <= stg_q[g-1];
    end
  end

  assign d_out = stg_q[STAGES-1];

endmodule

// File: rtl/adc_sif_chsel.sv
module adc_sif_chsel #(
  parameter int RES_W = 12
) (
  input  logic             single,
  input  logic             sel,
  input  logic [RES_W-1:0] ch0,
  input  logic [RES_W-1:0] ch1,
  output logic [RES_W-1:0] level
);

  logic [RES_W-1:0] pos, neg;

  always_comb begin
    pos = sel ? ch1 : ch0;
    neg = sel ? ch0 : ch1;
    if (single)         level = pos;
    else if (pos > neg) level = pos - neg;
    else                level = '0;
  end

endmodule

// File: rtl/adc_sif_sar.sv
module adc_sif_sar #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [RES_W-1:0] level_in,
  input  logic             step,
  output logic             keep,
  output logic [RES_W-1:0] result
);

  logic [RES_W-1:0] held_q, code_q, mask_q, trial;

  assign trial  = code_q | mask_q;
  assign keep   = (trial <= held_q);
  assign result = code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
      code_q <= '0;
      mask_q <= '0;
    end else if (load) begin
      held_q <= level_in;
      code_q <= '0;
      mask_q <= {1'b1, {(RES_W-1){1'b0}}};
    end else if (step) begin
      if (keep) code_q <= trial;
      mask_q <= mask_q >> 1;
    end
  end

endmodule

// File: rtl/adc_sif_engine.sv
module adc_sif_engine
  import adc_sif_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             sdi,
  input  logic [RES_W-1:0] ch0_code,
  input  logic [RES_W-1:0] ch1_code,
  output logic             sdo,
  output logic             sdo_en,
  output logic             sample_win,
  output logic             standby
);

  localparam int IDX_W = $clog2(RES_W);
  localparam int CNT_W = $clog2(CFG_BITS + 1);

  // Synchronize the three serial pins together so sdi aligns with sclk
  logic [2:0] pins_s;
  adc_sif_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_in({sdi, sclk, cs_n}), .d_out(pins_s)
  );

  logic [1:0] prev_q;
  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pins_s[1:0];
  end

  logic cs_hi, cs_fall, sck_rise, sck_fall, din;
  assign cs_hi    = pins_s[0];
  assign cs_fall  = prev_q[0] & ~pins_s[0];
  assign sck_rise = pins_s[1] & ~prev_q[1];
  assign sck_fall = ~pins_s[1] & prev_q[1];
  assign din      = pins_s[2];

  eng_state_t       state_q;
  logic [CNT_W-1:0] cfg_cnt_q;
  logic             single_q, sel_q, msb_only_q;
  logic [IDX_W-1:0] idx_q;

  logic             close_evt, step_evt, sar_keep;
  logic [RES_W-1:0] sel_level, sar_result;

  assign close_evt = (state_q == S_CFG) && sck_fall && !cs_hi &&
                     (cfg_cnt_q == CNT_W'(CFG_BITS));
  assign step_evt  = (state_q == S_CONV) && sck_fall && !cs_hi;

  adc_sif_chsel #(.RES_W(RES_W)) u_chsel (
    .single(single_q), .sel(sel_q), .ch0(ch0_code), .ch1(ch1_code),
    .level(sel_level)
  );

  adc_sif_sar #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst(rst), .load(close_evt), .level_in(sel_level),
    .step(step_evt), .keep(sar_keep), .result(sar_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_OFF;
      cfg_cnt_q  <= '0;
      single_q   <= 1'b0;
      sel_q      <= 1'b0;
      msb_only_q <= 1'b0;
      idx_q      <= '0;
      sdo        <= 1'b0;
      sdo_en     <= 1'b0;
      sample_win <= 1'b0;
      standby    <= 1'b1;
    end else if (cs_hi) begin
      state_q    <= S_OFF;
      sdo        <= 1'b0;
      sdo_en     <= 1'b0;
      sample_win <= 1'b0;
      standby    <= 1'b1;
    end else begin
      case (state_q)
        S_OFF: begin
          if (cs_fall) begin
            state_q <= S_HUNT;
            standby <= 1'b0;
          end
        end
        S_HUNT: begin
          if (sck_rise && din) begin
            state_q   <= S_CFG;
            cfg_cnt_q <= '0;
          end
        end
        S_CFG: begin
          if (sck_rise && (cfg_cnt_q < CNT_W'(CFG_BITS))) begin
            case (cfg_cnt_q)
              CNT_W'(0): single_q <= din;
              CNT_W'(1): begin
                sel_q      <= din;
                sample_win <= 1'b1;
              end
              default:   msb_only_q <= din;
            endcase
            cfg_cnt_q <= cfg_cnt_q + 1'b1;
          end else if (close_evt) begin
            sample_win <= 1'b0;
            sdo_en     <= 1'b1;
            sdo        <= 1'b0;
            idx_q      <= IDX_W'(RES_W - 1);
            state_q    <= S_CONV;
          end
        end
        S_CONV: begin
          if (sck_fall) begin
            sdo <= sar_keep;
            if (idx_q == '0) begin
              idx_q   <= IDX_W'(1);
              state_q <= msb_only_q ? S_FILL : S_REPLAY;
            end else begin
              idx_q <= idx_q - 1'b1;
            end
          end
        end
        S_REPLAY: begin
          if (sck_fall) begin
            sdo <= sar_result[idx_q];
            if (idx_q == IDX_W'(RES_W - 1)) state_q <= S_FILL;
            else                            idx_q   <= idx_q + 1'b1;
          end
        end
        S_FILL: begin
          if (sck_fall) sdo <= 1'b0;
        end
        default: state_q <= S_OFF;
      endcase
    end
  end

endmodule

// File: rtl/adc_sif_engine_chk.sv
module adc_sif_engine_chk (
  input logic clk,
  input logic rst,
  input logic cs_hi,
  input logic sck_fall,
  input logic sdo,
  input logic sdo_en,
  input logic sample_win,
  input logic standby
);

  // R1: standby never coexists with a driven output or an open window
  a_r1_standby_quiet: assert property (@(posedge clk) disable iff (rst)
    standby |-> (!sdo_en && !sample_win));

  // R5: the window and the output drive never overlap
  a_r5_window_not_driving: assert property (@(posedge clk) disable iff (rst)
    sample_win |-> !sdo_en);

  // R6: output drive begins with a low null bit as the window closes
  a_r6_null_on_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_en) |-> (!sdo && $fell(sample_win)));

  // R7: data moves only after a serial falling edge or a select rise
  a_r7_sdo_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo) |-> ($past(sck_fall) || $past(cs_hi)));

  // R11: select high ends the frame
  a_r11_select_ends: assert property (@(posedge clk) disable iff (rst)
    cs_hi |=> (!sdo_en && standby && !sample_win));

endmodule

bind adc_sif_engine adc_sif_engine_chk u_chk (
  .clk(clk), .rst(rst), .cs_hi(cs_hi), .sck_fall(sck_fall),
  .sdo(sdo), .sdo_en(sdo_en), .sample_win(sample_win), .standby(standby)
);

// File: tb/adc_sif_engine_tb_top.sv
module adc_sif_engine_tb_top;

  localparam int RES_W = 12;
  localparam int SYNC  = 2;
  localparam int LAT   = SYNC + 1;
  localparam int HP    = 6;

  logic clk = 1'b0;
  logic rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [RES_W-1:0] ch0 = '0, ch1 = '0;
  logic sdo, sdo_en, sample_win, standby;

  always #2 clk = ~clk;

  adc_sif_engine #(.RES_W(RES_W), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .ch0_code(ch0), .ch1_code(ch1), .sdo(sdo), .sdo_en(sdo_en),
    .sample_win(sample_win), .standby(standby)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // drive requests
  logic rst_v = 1'b1, cs_v = 1'b1, sclk_v = 1'b0, sdi_v = 1'b0;

  // behavioural model
  bit m_primed, m_act, m_hunt, m_closed, m_sgl, m_odd, m_msbf;
  int m_nr;
  bit p_cs = 1'b1, p_sclk = 1'b0;
  bit q_bits[$];
  logic e_sdo = 0, e_oe = 0, e_smp = 0, e_sb = 1;
  logic [3:0] hist [LAT];
  localparam logic [3:0] RST_VEC = 4'b1000;

  initial for (int k = 0; k < LAT; k++) hist[k] = RST_VEC;

  function automatic logic [RES_W-1:0] ref_code(bit sgl, bit odd,
      logic [RES_W-1:0] a, logic [RES_W-1:0] b);
    int p, n;
    p = odd ? int'(b) : int'(a);
    n = odd ? int'(a) : int'(b);
    if (sgl) return RES_W'(p);
    return (p > n) ? RES_W'(p - n) : '0;
  endfunction

  task automatic chk(input string tag, input string what, input logic got,
                     input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %b exp %b t=%0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic chkw(input string tag, input string what,
                      input logic [RES_W-1:0] got, input logic [RES_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h t=%0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic model_update();
    logic [RES_W-1:0] c;
    if (rst_v) begin
      m_primed = 0; m_act = 0; m_hunt = 0; m_closed = 0; m_nr = 0;
      e_sdo = 0; e_oe = 0; e_smp = 0; e_sb = 1; q_bits.delete();
    end else if (cs_v) begin
      m_primed = 1; m_act = 0;
      e_sdo = 0; e_oe = 0; e_smp = 0; e_sb = 1; q_bits.delete();
    end else if (p_cs && m_primed && !m_act) begin
      m_act = 1; m_hunt = 1; m_nr = 0; m_closed = 0; e_sb = 0;
    end else if (m_act) begin
      if (sclk_v && !p_sclk) begin
        if (m_hunt) begin
          if (sdi_v) begin m_hunt = 0; m_nr = 0; end
        end else if (m_nr < 3) begin
          m_nr++;
          if (m_nr == 1) m_sgl = sdi_v;
          else if (m_nr == 2) begin m_odd = sdi_v; e_smp = 1; end
          else m_msbf = sdi_v;
        end
      end else if (!sclk_v && p_sclk && !m_hunt && m_nr == 3) begin
        if (!m_closed) begin
          m_closed = 1; e_smp = 0; e_oe = 1; e_sdo = 0;
          c = ref_code(m_sgl, m_odd, ch0, ch1);
          for (int i = RES_W - 1; i >= 0; i--) q_bits.push_back(c[i]);
          if (!m_msbf) for (int i = 1; i < RES_W; i++) q_bits.push_back(c[i]);
        end else begin
          e_sdo = (q_bits.size() > 0) ? q_bits.pop_front() : 1'b0;
        end
      end
    end
    p_cs = cs_v; p_sclk = sclk_v;
  endtask

  // one system clock per iteration: compare, then drive and advance the model
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R7",  "sdo",        sdo,        hist[LAT-1][0]);
      chk("R6",  "sdo_en",     sdo_en,     hist[LAT-1][1]);
      chk("R5",  "sample_win", sample_win, hist[LAT-1][2]);
      chk("R11", "standby",    standby,    hist[LAT-1][3]);
      for (int k = LAT - 1; k > 0; k--) hist[k] = hist[k-1];
      rst = rst_v; cs_n = cs_v; sclk = sclk_v; sdi = sdi_v;
      model_update();
      hist[0] = {e_sb, e_smp, e_oe, e_sdo};
      if (rst_v) for (int k = 0; k < LAT; k++) hist[k] = RST_VEC;
    end
  endtask

  task automatic frame(input int lead, input bit sgl, input bit odd,
                       input bit msbf, input logic [RES_W-1:0] c0,
                       input logic [RES_W-1:0] c1, input int nclk,
                       input bit idle_hi, input string tag);
    logic rx [0:40];
    logic [RES_W-1:0] exp_c, word;
    int j, zstart;
    exp_c = ref_code(sgl, odd, c0, c1);
    ch0 = c0; ch1 = c1;
    sclk_v = idle_hi; cs_v = 1'b1; step(HP);
    cs_v = 1'b0; step(HP);
    for (int k = 0; k < lead + 1 + nclk; k++) begin
      j = k - lead;
      if (k < lead)           sdi_v = 1'b0;
      else if (j == 0)        sdi_v = 1'b1;
      else if (j == 1)        sdi_v = sgl;
      else if (j == 2)        sdi_v = odd;
      else if (j == 3)        sdi_v = msbf;
      else                    sdi_v = k[0];
      sclk_v = 1'b0; step(HP);
      if (j < 0) begin
        chk("R2", "sdo_en during leading zeros", sdo_en, 1'b0);
        chk("R2", "standby during leading zeros", standby, 1'b0);
      end
      if (j == 2) chk("R5", "window before 2nd rise", sample_win, 1'b0);
      if (j == 3) begin
        chk("R5", "window before order-bit rise", sample_win, 1'b1);
        chk("R6", "hi-Z before null", sdo_en, 1'b0);
      end
      if (j == 4) begin
        chk("R5", "window closed", sample_win, 1'b0);
        chk("R6", "enable at null", sdo_en, 1'b1);
        chk("R6", "null bit", sdo, 1'b0);
      end
      if (j >= 4) rx[j] = sdo;
      sclk_v = 1'b1; step(HP);
      if (j == 4) begin ch0 = ~c0; ch1 = ~c1; end
    end
    sclk_v = idle_hi; step(HP);
    cs_v = 1'b1; step(2 * HP);
    if (nclk >= 16) begin
      for (int b = 0; b < RES_W; b++) word[RES_W-1-b] = rx[5+b];
      chkw(tag, "R3 R7 R12 MSB-first word", word, exp_c);
    end
    if (!msbf && nclk >= 27) begin
      for (int b = 1; b < RES_W; b++)
        chk("R9", "LSB-first replay bit", rx[16+b], exp_c[b]);
    end
    zstart = msbf ? 17 : 28;
    for (int z = zstart; z <= nclk; z++) chk("R8", "zero fill", rx[z], 1'b0);
  endtask

  initial begin
    rst_v = 1'b1; cs_v = 1'b1; step(5);
    chk("R1", "standby after reset", standby, 1'b1);
    chk("R1", "hi-Z after reset", sdo_en, 1'b0);
    rst_v = 1'b0; step(6);

    frame(3, 1, 0, 1, 12'h5A3, 12'h0F0, 20, 0, "R4");
    frame(0, 1, 1, 0, 12'h123, 12'hABC, 31, 0, "R4");
    frame(7, 0, 0, 1, 12'h800, 12'h100, 19, 0, "R10");
    frame(1, 0, 1, 0, 12'h200, 12'h300, 30, 0, "R10");
    frame(2, 0, 0, 1, 12'h100, 12'h100, 18, 0, "R10");
    frame(0, 0, 1, 1, 12'h050, 12'h400, 20, 1, "R10");
    frame(0, 0, 0, 0, 12'h050, 12'h400, 29, 1, "R10");
    frame(4, 1, 1, 1, 12'h000, 12'hFFF, 19, 1, "R4");
    frame(5, 1, 0, 0, 12'h000, 12'h7FF, 30, 0, "R4");

    // select raised in the middle of the result
    frame(0, 1, 0, 1, 12'hAAA, 12'h555, 9, 0, "R11");
    chk("R11", "hi-Z after abort", sdo_en, 1'b0);
    chk("R11", "standby after abort", standby, 1'b1);

    // reset released with select low: a start bit must be ignored
    rst_v = 1'b1; cs_v = 1'b0; step(4);
    rst_v = 1'b0; step(6);
    for (int k = 0; k < 8; k++) begin
      sdi_v = 1'b1; sclk_v = 1'b0; step(HP);
      sclk_v = 1'b1; step(HP);
    end
    sclk_v = 1'b0; step(HP);
    chk("R1", "no frame without select high first", sdo_en, 1'b0);
    chk("R1", "standby held with select low", standby, 1'b1);
    frame(2, 0, 1, 0, 12'h123, 12'hFFF, 28, 0, "R1");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule